// File: doc/BRIEF.md
# Multi-Mode Accumulator Operand Fetch Unit

This unit carries out one load-accumulator operation at a time. The operand is located by one of nine addressing modes. A request gives a mode code, an address/offset field, a register select and the address of the following instruction. The unit works out where the operand lives, which may be the field itself, a register, memory or memory through a pointer. It reads memory over a single-port synchronous read interface with one cycle of latency. It then writes the result into the accumulator and raises a one-cycle done strobe.

The unit holds a small register file. The highest-numbered register by default acts as the index register, and it is advanced after every indexed access. A write port loads the registers while the unit is idle. Address arithmetic wraps at the address width. A relative offset is a two's-complement value added to the next-instruction address, so negative offsets reach backwards.

Top module: `opf_unit`

## Requirements
- R1: Mode code 0 (immediate) loads field_i into the accumulator with no memory read. done_o is high in the cycle after the accepting edge.
- R2: Mode code 1 (direct) makes one read at address field_i and loads the returned word. done_o is high in the cycle after the third edge, counting the accepting edge as the first.
- R3: Mode code 2 (indirect) reads at field_i to get a pointer, then reads at that pointer and loads the returned word. It makes two reads, and done_o is high after the fifth edge.
- R4: Mode code 3 (register direct) loads the register chosen by rsel_i with no memory read, with the same timing as R1.
- R5: Mode code 4 (register indirect) makes one read at the address held in the selected register, with the same timing as R2.
- R6: Mode code 5 (displacement) makes one read at field_i plus the selected register, modulo 2^W, with the same timing as R2.
- R7: Mode code 6 (relative) makes one read at npc_i plus field_i, with field_i taken as signed and the sum taken modulo 2^W. An offset of 5 with npc_i of 12 reads address 17.
- R8: Mode code 7 (indexed) makes one read at field_i plus the index register (register IDX, default 3). When the data returns, the index register is incremented by one.
- R9: Mode code 8 (clear) sets the accumulator to zero with no memory read, with the same timing as R1.
- R10: done_o lasts one cycle per operation, and the accumulator changes only in a cycle where done_o is high.
- R11: While busy_o is high, start_i and the register write port are ignored.
- R12: Mode codes 9 to 15 are ignored. There is no read, no done_o, and the accumulator is unchanged.
- R13: Each read asserts mem_req_o for one cycle. Read data is taken the cycle after the request, and requests are issued only while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request an operation (taken when idle) |
| mode_i | input | 4 | Addressing mode code |
| field_i | input | W | Address, offset or immediate field |
| rsel_i | input | RSW | Register select |
| npc_i | input | W | Address of the next instruction |
| rf_we_i | input | 1 | Register file write enable |
| rf_waddr_i | input | RSW | Register file write index |
| rf_wdata_i | input | W | Register file write data |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | W | Memory read address |
| mem_rdata_i | input | W | Memory read data, valid one cycle after request |
| acc_o | output | W | Accumulator |
| done_o | output | 1 | Operation complete strobe |
| busy_o | output | 1 | Operation in progress |

## Verification
The delay from the accepting edge to done_o depends only on how many reads the mode needs. Modes with no read finish after one edge, modes with one read after three, and indirect mode after five. The bench counts falling edges from the start of each request until done_o appears and compares that count with the expected value. It also counts memory requests over the same window. It samples the accumulator at that falling edge and checks at the next falling edge that done_o has dropped. Tests of ignored stimulus wait well past the longest latency before they sample the outputs.

// File: rtl/opf_pkg.sv
package opf_pkg;
  typedef enum logic [3:0] {
    M_IMM  = 4'd0,
    M_DIR  = 4'd1,
    M_IND  = 4'd2,
    M_REG  = 4'd3,
    M_RIND = 4'd4,
    M_DISP = 4'd5,
    M_REL  = 4'd6,
    M_IDX  = 4'd7,
    M_CLR  = 4'd8
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD1,
    S_WT1,
    S_RD2,
    S_WT2
  } state_e;

  function automatic logic mode_ok(input logic [3:0] m);
    return m <= 4'd8;
  endfunction

  function automatic logic mode_mem(input logic [3:0] m);
    return m inside {M_DIR, M_IND, M_RIND, M_DISP, M_REL, M_IDX};
  endfunction
endpackage

// File: rtl/opf_regfile.sv
module opf_regfile #(
  parameter int unsigned W    = 8,
  parameter int unsigned NREG = 4,
  parameter int unsigned IDX  = 3,
  localparam int unsigned RSW = $clog2(NREG)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [RSW-1:0] waddr_i,
  input  logic [W-1:0]   wdata_i,
  input  logic [RSW-1:0] raddr_i,
  output logic [W-1:0]   rdata_o,
  output logic [W-1:0]   idx_o,
  input  logic           idx_inc_i
);
  logic [W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g] <= '0;
      end else if (we_i && waddr_i == RSW'(g)) begin
        regs_q[g] <= wdata_i;
      end else if (g == IDX && idx_inc_i) begin
        regs_q[g] <= regs_q[g] + W'(1);
      end
    end
  end

  assign rdata_o = regs_q[raddr_i];
  assign idx_o   = regs_q[IDX];
endmodule

// File: rtl/opf_agu.sv
module opf_agu
  import opf_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [3:0]   mode_i,
  input  logic [W-1:0] field_i,
  input  logic [W-1:0] reg_i,
  input  logic [W-1:0] idx_i,
  input  logic [W-1:0] npc_i,
  output logic [W-1:0] ea_o,
  output logic [W-1:0] direct_o
);
  // sums wrap at W bits; signed offset add equals unsigned add mod 2^W
  always_comb begin
    unique case (mode_i)
      M_RIND:  ea_o = reg_i;
      M_DISP:  ea_o = field_i + reg_i;
      M_REL:   ea_o = npc_i + field_i;
      M_IDX:   ea_o = field_i + idx_i;
      default: ea_o = field_i;
    endcase
  end

  always_comb begin
    unique case (mode_i)
      M_REG:   direct_o = reg_i;
      M_CLR:   direct_o = '0;
      default: direct_o = field_i;
    endcase
  end
endmodule

// File: rtl/opf_seq.sv
module opf_seq
  import opf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [3:0] mode_i,
  output logic       accept_o,
  output logic       direct_we_o,
  output logic       mem_req_o,
  output logic       mem_we_o,
  output logic       ptr_load_o,
  output logic       idx_inc_o,
  output logic       busy_o
);
  state_e     state_q, state_d;
  logic [3:0] mode_q;

  assign accept_o    = start_i && state_q == S_IDLE && mode_ok(mode_i);
  assign direct_we_o = accept_o && !mode_mem(mode_i);
  assign mem_req_o   = state_q == S_RD1 || state_q == S_RD2;
  assign ptr_load_o  = state_q == S_WT1 && mode_q == M_IND;
  assign mem_we_o    = (state_q == S_WT1 && mode_q != M_IND) || state_q == S_WT2;
  assign idx_inc_o   = state_q == S_WT1 && mode_q == M_IDX;
  assign busy_o      = state_q != S_IDLE;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (accept_o && mode_mem(mode_i)) state_d = S_RD1;
      S_RD1:  state_d = S_WT1;
      S_WT1:  state_d = (mode_q == M_IND) ? S_RD2 : S_IDLE;
      S_RD2:  state_d = S_WT2;
      S_WT2:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      mode_q  <= 4'd0;
    end else begin
      state_q <= state_d;
      if (accept_o) mode_q <= mode_i;
    end
  end
endmodule

// File: rtl/opf_unit.sv
module opf_unit #(
  parameter int unsigned W    = 8,
  parameter int unsigned NREG = 4,
  parameter int unsigned IDX  = NREG - 1,
  localparam int unsigned RSW = $clog2(NREG)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [3:0]     mode_i,
  input  logic [W-1:0]   field_i,
  input  logic [RSW-1:0] rsel_i,
  input  logic [W-1:0]   npc_i,
  input  logic           rf_we_i,
  input  logic [RSW-1:0] rf_waddr_i,
  input  logic [W-1:0]   rf_wdata_i,
  output logic           mem_req_o,
  output logic [W-1:0]   mem_addr_o,
  input  logic [W-1:0]   mem_rdata_i,
  output logic [W-1:0]   acc_o,
  output logic           done_o,
  output logic           busy_o
);
  logic         accept, direct_we, mem_we, ptr_load, idx_inc, busy;
  logic [W-1:0] reg_val, idx_val, ea, direct_val;
  logic [W-1:0] addr_q, acc_q;
  logic         done_q;

  opf_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .accept_o    (accept),
    .direct_we_o (direct_we),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we),
    .ptr_load_o  (ptr_load),
    .idx_inc_o   (idx_inc),
    .busy_o      (busy)
  );

  opf_regfile #(.W(W), .NREG(NREG), .IDX(IDX)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we_i && !busy),
    .waddr_i   (rf_waddr_i),
    .wdata_i   (rf_wdata_i),
    .raddr_i   (rsel_i),
    .rdata_o   (reg_val),
    .idx_o     (idx_val),
    .idx_inc_i (idx_inc)
  );

  opf_agu #(.W(W)) u_agu (
    .mode_i   (mode_i),
    .field_i  (field_i),
    .reg_i    (reg_val),
    .idx_i    (idx_val),
    .npc_i    (npc_i),
    .ea_o     (ea),
    .direct_o (direct_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (accept)        addr_q <= ea;
      else if (ptr_load) addr_q <= mem_rdata_i;
      if (direct_we)     acc_q <= direct_val;
      else if (mem_we)   acc_q <= mem_rdata_i;
      done_q <= direct_we || mem_we;
    end
  end

  assign mem_addr_o = addr_q;
  assign acc_o      = acc_q;
  assign done_o     = done_q;
  assign busy_o     = busy;
endmodule

// File: rtl/opf_unit_chk.sv
module opf_unit_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [3:0]   mode_i,
  input logic [W-1:0] field_i,
  input logic         mem_req_o,
  input logic [W-1:0] acc_o,
  input logic         done_o,
  input logic         busy_o
);
  logic idle_go;
  assign idle_go = start_i && !busy_o;

  AST_IMM_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_go && mode_i == 4'd0) |=> (done_o && acc_o == $past(field_i))); // R1
  AST_MEM_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_go && mode_i inside {4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd7}) |=> (mem_req_o && busy_o)); // R2
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_go && mode_i == 4'd8) |=> (done_o && acc_o == '0)); // R9
  AST_ACC_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(acc_o) |-> done_o); // R10
  AST_BAD_MODE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_go && mode_i > 4'd8) |=> (!done_o && !busy_o)); // R12
  AST_REQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R13
  AST_REQ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o); // R13
endmodule

bind opf_unit opf_unit_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .mode_i    (mode_i),
  .field_i   (field_i),
  .mem_req_o (mem_req_o),
  .acc_o     (acc_o),
  .done_o    (done_o),
  .busy_o    (busy_o)
);

// File: tb/opf_unit_tb.sv
module opf_unit_tb_top;
  localparam int W = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] mode = '0;
  logic [7:0] field = '0;
  logic [1:0] rsel = '0;
  logic [7:0] npc = '0;
  logic       rf_we = 1'b0;
  logic [1:0] rf_waddr = '0;
  logic [7:0] rf_wdata = '0;
  logic       mem_req_o;
  logic [7:0] mem_addr_o;
  logic [7:0] mem_rdata = '0;
  logic [7:0] acc_o;
  logic       done_o, busy_o;

  int n_chk = 0;
  int n_err = 0;
  int rd_cnt = 0;
  logic [7:0] rm [4];

  always #10 clk = ~clk;

  opf_unit #(.W(W), .NREG(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .field_i(field), .rsel_i(rsel), .npc_i(npc),
    .rf_we_i(rf_we), .rf_waddr_i(rf_waddr), .rf_wdata_i(rf_wdata),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata),
    .acc_o(acc_o), .done_o(done_o), .busy_o(busy_o)
  );

  function automatic logic [7:0] mf(input logic [7:0] a);
    return 8'(a * 13 + 7);
  endfunction

  always @(posedge clk) begin
    if (mem_req_o) begin
      mem_rdata <= mf(mem_addr_o);
      rd_cnt    <= rd_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    rf_we = 1'b1; rf_waddr = a; rf_wdata = d;
    @(negedge clk);
    rf_we = 1'b0;
    rm[a] = d;
  endtask

  task automatic run(input logic [3:0] m, input logic [7:0] f, input logic [1:0] rs,
                     input logic [7:0] pc, input logic [7:0] exp, input int lat,
                     input int rds, input string tag);
    int n;
    int r0;
    @(negedge clk);
    mode = m; field = f; rsel = rs; npc = pc; start = 1'b1;
    r0 = rd_cnt;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done_o && n < 12) begin
      @(negedge clk);
      n++;
    end
    chk(done_o && acc_o == exp, {tag, " value"}, int'(acc_o), int'(exp));
    chk(n == lat, {tag, " latency"}, n, lat);
    chk(rd_cnt - r0 == rds, {tag, " reads"}, rd_cnt - r0, rds);
    @(negedge clk);
    chk(!done_o, {"R10 done width ", tag}, int'(done_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [7:0] e;
    repeat (3) @(negedge clk);
    chk(acc_o == 8'd0 && !done_o && !busy_o && !mem_req_o, "R10 reset state", int'(acc_o), 0);
    rst_n = 1'b1;

    wr_reg(2'd0, 8'h11);
    wr_reg(2'd1, 8'h80);
    wr_reg(2'd2, 8'hF3);
    wr_reg(2'd3, 8'h05);

    for (int f = 0; f < 256; f++) begin
      run(4'd0, 8'(f), 2'd0, 8'd0, 8'(f), 1, 0, "R1 immediate");
      run(4'd1, 8'(f), 2'd0, 8'd0, mf(8'(f)), 3, 1, "R2 direct");
      run(4'd2, 8'(f), 2'd0, 8'd0, mf(mf(8'(f))), 5, 2, "R3 indirect");
    end

    for (int rs = 0; rs < 4; rs++) begin
      for (int f = 0; f < 256; f += 17) begin
        run(4'd3, 8'(f), 2'(rs), 8'd0, rm[rs], 1, 0, "R4 register direct");
        run(4'd4, 8'(f), 2'(rs), 8'd0, mf(rm[rs]), 3, 1, "R5 register indirect");
        e = 8'(f) + rm[rs];
        run(4'd5, 8'(f), 2'(rs), 8'd0, mf(e), 3, 1, "R6 displacement");
        run(4'd6, 8'(f), 2'(rs), 8'(f * 3 + rs), mf(8'(f * 4 + rs)), 3, 1, "R7 relative");
        e = 8'(f) + rm[3];
        run(4'd7, 8'(f), 2'(rs), 8'd0, mf(e), 3, 1, "R8 indexed");
        rm[3] = rm[3] + 8'd1;
        run(4'd3, 8'd0, 2'd3, 8'd0, rm[3], 1, 0, "R8 index incremented");
      end
    end

    // relative corner cases: example address and negative offset wrap
    run(4'd6, 8'd5, 2'd0, 8'd12, mf(8'd17), 3, 1, "R7 offset example");
    run(4'd6, 8'hFB, 2'd0, 8'd3, mf(8'd254), 3, 1, "R7 negative wrap");
    run(4'd6, 8'd10, 2'd0, 8'd250, mf(8'd4), 3, 1, "R7 positive wrap");

    // index register wraps past all ones
    wr_reg(2'd3, 8'hFF);
    run(4'd7, 8'd2, 2'd0, 8'd0, mf(8'd1), 3, 1, "R8 index at max");
    run(4'd3, 8'd0, 2'd3, 8'd0, 8'h00, 1, 0, "R8 index wrap");
    rm[3] = 8'h00;

    // clear
    run(4'd0, 8'hA5, 2'd0, 8'd0, 8'hA5, 1, 0, "R1 preload");
    run(4'd8, 8'h77, 2'd2, 8'd0, 8'h00, 1, 0, "R9 clear");
    run(4'd1, 8'h40, 2'd0, 8'd0, mf(8'h40), 3, 1, "R13 read after clear");

    // start and register write during busy are ignored
    begin
      int r0;
      int dn;
      @(negedge clk);
      mode = 4'd2; field = 8'h20; start = 1'b1;
      r0 = rd_cnt;
      @(negedge clk);
      mode = 4'd0; field = 8'h55;
      rf_we = 1'b1; rf_waddr = 2'd0; rf_wdata = 8'h99;
      @(negedge clk);
      start = 1'b0; rf_we = 1'b0;
      dn = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (done_o) dn++;
      end
      chk(acc_o == mf(mf(8'h20)), "R11 start ignored value", int'(acc_o), int'(mf(mf(8'h20))));
      chk(dn == 1, "R11 single done", dn, 1);
      chk(rd_cnt - r0 == 2, "R11 read count", rd_cnt - r0, 2);
      run(4'd3, 8'd0, 2'd0, 8'd0, rm[0], 1, 0, "R11 write ignored");
    end

    // undefined mode codes
    run(4'd0, 8'h3C, 2'd0, 8'd0, 8'h3C, 1, 0, "R12 preload");
    for (int m = 9; m < 16; m++) begin
      int r0;
      int dn;
      @(negedge clk);
      mode = 4'(m); field = 8'hE1; start = 1'b1;
      r0 = rd_cnt;
      @(negedge clk);
      start = 1'b0;
      dn = 0;
      for (int i = 0; i < 6; i++) begin
        if (done_o || busy_o) dn++;
        @(negedge clk);
      end
      chk(dn == 0, "R12 no activity", dn, 0);
      chk(rd_cnt == r0, "R12 no read", rd_cnt - r0, 0);
      chk(acc_o == 8'h3C, "R12 acc kept", int'(acc_o), 8'h3C);
    end

    summary();
  end
endmodule